// File: doc/BRIEF.md
# Dual-Clock Programmable-Flag FIFO

This block is a first-in first-out buffer whose write side and read side each run on their own clock. The two clocks may be the same net or fully unrelated. Words are 18 bits wide and the depth is a power-of-two parameter, 256 entries by default. Both data sides use a valid/ready handshake. On the write side a word is taken on a write-clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls when the buffer is full, so the producer has to hold its word until space appears. On the read side the word at the head is presented combinationally with `rd_valid`. It is consumed on a read-clock edge where `rd_valid` and `rd_ready` are both high. A consumer that keeps `rd_ready` low holds the head word in place for as long as it likes.

The block drives five status flags: empty, full, almost-empty, almost-full and half-full. The almost thresholds are two 18-bit offsets. Each resets to 7. New values are loaded by raising `ld_mode` and presenting words on the write port. In that mode each accepted word goes into the next offset half rather than into storage. The order is empty-threshold low half, empty-threshold high half, full-threshold low half, full-threshold high half, and then it wraps. The `out_en` input gates the read port. While it is low, the read data is forced to zero and `rd_valid` is held low.

Top module: `afifo_progflags`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `almost_empty`=1, `almost_full`=0, `half_full`=0, `wr_ready`=1 and `rd_valid`=0.
- R2: Words leave the read port in the order they were accepted, with their values unchanged.
- R3: While the fill level equals the depth, `full`=1 and `wr_ready`=0 outside load mode, and a write attempt stores nothing.
- R4: While `empty`=1, `rd_valid`=0, and asserting `rd_ready` consumes nothing. A later word is still read correctly.
- R5: `almost_empty`=1 exactly when the fill level seen by the read side is less than or equal to the empty threshold (reset value 7).
- R6: `almost_full`=1 exactly when depth minus the fill level seen by the write side is less than or equal to the full threshold (reset value 7).
- R7: `half_full`=1 exactly when the fill level seen by the write side is at least depth/2.
- R8: While `ld_mode`=1, `wr_ready`=1 and each accepted word is stored nowhere in the data path. Instead, its bits [8:0] go to the next threshold half in the order: empty-threshold bits [8:0], empty-threshold bits [17:9], full-threshold bits [8:0], full-threshold bits [17:9]. After the last half the order starts again at the first.
- R9: While `out_en`=0, `rd_valid`=0 and `rd_data`=0, and no word is consumed.
- R10: Reset restores both thresholds to 7 and returns the load order to the empty-threshold low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_valid | input | 1 | Producer has a word on `wr_data` |
| wr_ready | output | 1 | Word is accepted this edge (space available, or load mode) |
| wr_data | input | 18 | Write word, or threshold half in load mode |
| ld_mode | input | 1 | Route accepted writes to the threshold sequencer |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_valid | output | 1 | Head word present and port enabled |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_data | output | 18 | Head word, zero while disabled |
| out_en | input | 1 | Read port enable |
| empty | output | 1 | No words seen by read side |
| full | output | 1 | Depth reached as seen by write side |
| almost_empty | output | 1 | Fill level at or below empty threshold |
| almost_full | output | 1 | Free space at or below full threshold |
| half_full | output | 1 | Fill level at or above half the depth |

## Verification
The assertions run on every cycle and check the pointer safety rules. The write pointer never advances while full or in load mode. The read pointer never advances while empty or while the port is disabled. The bench scenarios cover the rest. Its scoreboard shows that the data arrives in order, with nothing extra, dropped or repeated, after long fills and drains across unrelated clocks. It also compares the threshold flags at their exact switching levels, before and after offsets are loaded. Through observed flag changes it shows that load writes land in the documented order, that the order wraps, and that reset brings back the defaults.

// File: rtl/afifo_pf_pkg.sv
package afifo_pf_pkg;
  localparam int DEFAULT_OFFSET = 7;

  typedef enum logic [1:0] {
    SEL_AE_LO = 2'd0,
    SEL_AE_HI = 2'd1,
    SEL_AF_LO = 2'd2,
    SEL_AF_HI = 2'd3
  } off_sel_e;
endpackage

// File: rtl/ptr_cross.sv
module ptr_cross #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_out[W-1] = sync_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
  import afifo_pf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          ld_mode,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   rbin_s,
  output logic          wr_ready,
  output logic          push,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          almost_full,
  output logic          half_full,
  output logic [DW-1:0] ae_off
);
  localparam int PART = DW / 2;
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  logic [DW-1:0] af_off;
  off_sel_e      sel;
  logic [AW:0]   level, space;
  logic          load;

  assign level       = wbin - rbin_s;
  assign space       = DEPTH_V - level;
  assign full        = level[AW];
  assign half_full   = level[AW] | level[AW-1];
  assign almost_full = DW'(space) <= af_off;
  assign wr_ready    = ld_mode | ~full;
  assign push        = wr_valid & ~ld_mode & ~full;
  assign load        = wr_valid & ld_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin + 1'b1;
      wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel    <= SEL_AE_LO;
      ae_off <= DW'(DEFAULT_OFFSET);
      af_off <= DW'(DEFAULT_OFFSET);
    end else if (load) begin
      case (sel)
        SEL_AE_LO: begin ae_off[PART-1:0]  <= wr_data[PART-1:0]; sel <= SEL_AE_HI; end
        SEL_AE_HI: begin ae_off[DW-1:PART] <= wr_data[PART-1:0]; sel <= SEL_AF_LO; end
        SEL_AF_LO: begin af_off[PART-1:0]  <= wr_data[PART-1:0]; sel <= SEL_AF_HI; end
        default:   begin af_off[DW-1:PART] <= wr_data[PART-1:0]; sel <= SEL_AE_LO; end
      endcase
    end
  end
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ready,
  input  logic          out_en,
  input  logic [AW:0]   wbin_s,
  input  logic [DW-1:0] ae_off,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          rd_valid,
  output logic          empty,
  output logic          almost_empty
);
  logic [AW:0] level;
  logic        pop;

  assign level        = wbin_s - rbin;
  assign empty        = (level == '0);
  assign almost_empty = DW'(level) <= ae_off;
  assign rd_valid     = out_en & ~empty;
  assign pop          = rd_valid & rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin + 1'b1;
      rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
    end
  end
endmodule

// File: rtl/afifo_progflags.sv
module afifo_progflags #(
  parameter int DEPTH = 256,
  parameter int DW    = 18
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          ld_mode,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic          out_en,
  output logic          empty,
  output logic          full,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          half_full
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]   wbin, wgray, rbin, rgray, wbin_s, rbin_s;
  logic [DW-1:0] ae_off;
  logic          push;
  logic [DW-1:0] mem [DEPTH];

  fifo_wr_side #(.AW(AW), .DW(DW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_valid(wr_valid), .ld_mode(ld_mode),
    .wr_data(wr_data), .rbin_s(rbin_s), .wr_ready(wr_ready), .push(push),
    .wbin(wbin), .wgray(wgray), .full(full), .almost_full(almost_full),
    .half_full(half_full), .ae_off(ae_off)
  );

  fifo_rd_side #(.AW(AW), .DW(DW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_ready(rd_ready), .out_en(out_en),
    .wbin_s(wbin_s), .ae_off(ae_off), .rbin(rbin), .rgray(rgray),
    .rd_valid(rd_valid), .empty(empty), .almost_empty(almost_empty)
  );

  ptr_cross #(.W(AW + 1)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wgray), .bin_out(wbin_s)
  );

  ptr_cross #(.W(AW + 1)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rgray), .bin_out(rbin_s)
  );

  always_ff @(posedge wr_clk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data;
  end

  assign rd_data = out_en ? mem[rbin[AW-1:0]] : '0;
endmodule

// File: rtl/afifo_progflags_checks.sv
module afifo_progflags_checks #(
  parameter int AW = 8
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        wr_rst_n,
  input logic        rd_rst_n,
  input logic        ld_mode,
  input logic        full,
  input logic        empty,
  input logic        out_en,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin
);
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full |=> $stable(wbin));

  assert_load_skips_store_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    ld_mode |=> $stable(wbin));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    empty |=> $stable(rbin));

  assert_disabled_holds_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !out_en |=> $stable(rbin));
endmodule

bind afifo_progflags afifo_progflags_checks #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .ld_mode(ld_mode), .full(full), .empty(empty), .out_en(out_en),
  .wbin(wbin), .rbin(rbin)
);

// File: tb/sim_afifo_progflags.sv
module sim_afifo_progflags;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int DEPTH = 256;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_valid = 0, ld_mode = 0, rd_ready = 0, out_en = 1;
  logic [17:0] wr_data = '0;
  logic wr_ready, rd_valid, empty, full, almost_empty, almost_full, half_full;
  logic [17:0] rd_data;

  int checks = 0, errors = 0;
  logic [17:0] exp_q[$];

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  afifo_progflags #(.DEPTH(DEPTH), .DW(18)) u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .ld_mode(ld_mode), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .out_en(out_en),
    .empty(empty), .full(full), .almost_empty(almost_empty),
    .almost_full(almost_full), .half_full(half_full)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [17:0] d);
    @(negedge wr_clk);
    wr_valid = 1;
    wr_data  = d;
    if (!ld_mode && wr_ready) exp_q.push_back(d);
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic drain();
    @(posedge rd_clk); #2 rd_ready = 1;
    while (exp_q.size() != 0) @(posedge rd_clk);
    repeat (3) @(posedge rd_clk);
    #2 rd_ready = 0;
    settle();
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    wr_rst_n = 0; rd_rst_n = 0;
    exp_q.delete();
    repeat (3) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    settle();
  endtask

  // scoreboard monitor (R2)
  initial begin
    forever begin
      @(negedge rd_clk);
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) check("R2 unexpected word", 32'(rd_data), 32'h0);
        else check("R2 data order", 32'(rd_data), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(WR_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
    check("R1 almost_empty", 32'(almost_empty), 1);
    check("R1 almost_full", 32'(almost_full), 0);
    check("R1 half_full", 32'(half_full), 0);
    check("R1 wr_ready", 32'(wr_ready), 1);
    check("R1 rd_valid", 32'(rd_valid), 0);

    // R5 default empty threshold edge
    for (int i = 0; i < 7; i++) push(18'h100 + 18'(i));
    settle();
    check("R5 level7 almost_empty", 32'(almost_empty), 1);
    push(18'h2aaaa);
    settle();
    check("R5 level8 almost_empty", 32'(almost_empty), 0);
    check("R2 rd_valid with data", 32'(rd_valid), 1);
    drain();
    check("R4 empty after drain", 32'(empty), 1);

    // R4 read while empty
    @(posedge rd_clk); #2 rd_ready = 1;
    repeat (5) @(negedge wr_clk);
    check("R4 rd_valid while empty", 32'(rd_valid), 0);
    @(posedge rd_clk); #2 rd_ready = 0;
    push(18'h15a5a);
    settle();
    drain();

    // R7 R6 R3 fill to depth
    for (int i = 0; i < DEPTH; i++) begin
      push(18'((i * 37 + 5) & 18'h3ffff));
      if (i == 126) check("R7 level127 half_full", 32'(half_full), 0);
      if (i == 127) check("R7 level128 half_full", 32'(half_full), 1);
      if (i == 247) check("R6 level248 almost_full", 32'(almost_full), 0);
      if (i == 248) check("R6 level249 almost_full", 32'(almost_full), 1);
      if (i == 254) check("R3 level255 full", 32'(full), 0);
    end
    check("R3 full at depth", 32'(full), 1);
    check("R3 wr_ready at depth", 32'(wr_ready), 0);
    push(18'h3ffff);
    check("R3 full after blocked write", 32'(full), 1);
    settle();

    // R9 port disabled
    @(posedge rd_clk); #2 out_en = 0;
    @(posedge rd_clk); #2 rd_ready = 1;
    repeat (6) @(negedge wr_clk);
    check("R9 rd_valid disabled", 32'(rd_valid), 0);
    check("R9 rd_data disabled", 32'(rd_data), 0);
    @(posedge rd_clk); #2 rd_ready = 0;
    @(posedge rd_clk); #2 out_en = 1;
    settle();
    check("R9 nothing consumed", 32'(full), 1);
    drain();
    check("R3 empty after full drain", 32'(empty), 1);

    // R8 load sequence with wrap
    @(negedge wr_clk); ld_mode = 1;
    check("R8 wr_ready in load", 32'(wr_ready), 1);
    push(18'd20); push(18'd1); push(18'd30); push(18'd0); push(18'd10);
    @(negedge wr_clk); ld_mode = 0;
    settle();
    check("R8 load words not stored", 32'(empty), 1);
    for (int i = 0; i < 11; i++) push(18'h3000 + 18'(i));
    settle();
    check("R8 high half raises empty threshold", 32'(almost_empty), 1);
    @(negedge wr_clk); ld_mode = 1;
    push(18'd0);
    @(negedge wr_clk); ld_mode = 0;
    settle();
    check("R8 wrapped low half level11", 32'(almost_empty), 0);
    for (int i = 11; i < 225; i++) push(18'h3000 + 18'(i));
    check("R6 level225 loaded threshold", 32'(almost_full), 0);
    push(18'h3fff0);
    check("R6 level226 loaded threshold", 32'(almost_full), 1);
    drain();

    // R10 reset restores defaults and sequencer
    do_reset();
    for (int i = 0; i < 8; i++) push(18'h500 + 18'(i));
    settle();
    check("R10 default empty threshold", 32'(almost_empty), 0);
    @(negedge wr_clk); ld_mode = 1;
    push(18'd9);
    @(negedge wr_clk); ld_mode = 0;
    settle();
    check("R10 sequencer at first half", 32'(almost_empty), 1);
    drain();
    check("R10 empty at end", 32'(empty), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule